// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives an SPI serial clock from the system clock. An 8-bit prescale code, written through a one-cycle strobe, selects the divisor. A build-time parameter chooses one of two code layouts.

The compact layout gives even divisors from 4 to 30. The wide layout multiplies a 4-bit linear factor by a power of two. Its 3-bit exponent is spread over non-adjacent bits of the code, so divisors reach 1920.

While a transfer is active, the block produces a toggling serial clock and a one-cycle enable in the last system cycle of each serial period. The idle level of the serial clock follows the polarity input. Picking a code for a target rate is left to software. There is no data stream here, so every pin is a plain control or status pin with no handshake.

Top module: `spi_clk_prescaler`

## Requirements
- R1: After reset, with no code written, the divisor is 4, `sclk` equals `cpol` and `sclk_en` is low.
- R2: While `active` is low, `sclk` equals `cpol` and `sclk_en` is low, and the period count restarts.
- R3: Compact layout (`WIDE_CODE`=0): only code bits 4:0 are used. Bits 7:5 are ignored. A value c from 0x12 to 0x1F gives a divisor of 2*(c-0x10), which covers the even values 4 to 30.
- R4: Compact layout: a code value in bits 4:0 below 0x12 gives a divisor of 4.
- R5: Wide layout (`WIDE_CODE`=1): the divisor is m*2^e. The factor m is bits 3:0. The exponent e has bit 2 from code bit 7, bit 1 from code bit 6 and bit 0 from code bit 4. Code bit 5 is ignored. Odd divisors are allowed.
- R6: Wide layout: a factor field of 0 is used as 1.
- R7: Every divisor lies in 4..1920. Wide products below 4 are raised to 4, and code 0xDF gives 1920.
- R8: With divisor D, counted from the first active cycle, the first ceil(D/2) cycles of each period show `sclk` = `cpol`. The remaining floor(D/2) cycles show the inverted level. `sclk_en` is high only in the last cycle of the period.
- R9: A code write, with `cfg_we` high at a clock edge, applies the new divisor and restarts the period from the next cycle, with no partial pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Strobe that loads `cfg_code` |
| cfg_code | input | 8 | Prescale code |
| cpol | input | 1 | Serial clock idle level |
| active | input | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| sclk_en | output | 1 | One-cycle pulse at the end of each serial period |

## Verification
A corrupt divisor register or period counter shows up directly on `sclk`. Its first toggle lands in the wrong cycle, which can be observed within ceil(D/2) cycles of activity starting. A wrong `sclk_en` shows no later than the end of the first period. A reload fault after a code write shows in the very next cycle as a serial clock off its idle level. The bench compares both outputs against a model every cycle, so any of these is reported in the cycle where it first appears.

// File: rtl/spi_psc_pkg.sv
package spi_psc_pkg;
  localparam int CODE_W   = 8;
  localparam int FACT_W   = 4;
  localparam int EXP_W    = 3;
  localparam int MIN_DIV  = 4;
  localparam int CMP_BASE = 16;
  localparam int MAX_DIV  = ((1 << FACT_W) - 1) * (1 << ((1 << EXP_W) - 1));
  localparam int DIV_W    = $clog2(MAX_DIV + 1);
  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/psc_dec_compact.sv
module psc_dec_compact
  import spi_psc_pkg::*;
(
  input  code_t code,
  output div_t  div
);
  localparam int LW = 5;
  logic [LW-1:0] low;
  logic [LW-1:0] half;

  always_comb begin
    low  = code[LW-1:0];
    half = low - LW'(CMP_BASE);
    if (low < LW'(CMP_BASE + MIN_DIV / 2)) div = div_t'(MIN_DIV);
    else                                   div = div_t'({half, 1'b0});
  end
endmodule

// File: rtl/psc_dec_wide.sv
module psc_dec_wide
  import spi_psc_pkg::*;
(
  input  code_t code,
  output div_t  div
);
  localparam int EXP_B0  = 4;
  localparam int EXP_HI  = 6;
  logic [FACT_W-1:0] fact;
  logic [EXP_W-1:0]  ex;
  div_t              prod;

  always_comb begin
    fact = (code[FACT_W-1:0] == '0) ? FACT_W'(1) : code[FACT_W-1:0];
    ex   = {code[EXP_HI+1], code[EXP_HI], code[EXP_B0]};
    prod = div_t'(fact) << ex;
    div  = (prod < div_t'(MIN_DIV)) ? div_t'(MIN_DIV) : prod;
  end
endmodule

// File: rtl/psc_divider.sv
module psc_divider
  import spi_psc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  div_t div_in,
  input  logic active,
  input  logic cpol,
  output logic sclk,
  output logic sclk_en
);
  div_t div_q;
  div_t cnt;
  div_t first_half;
  logic last;

  always_comb begin
    first_half = div_q - (div_q >> 1);
    last       = (cnt == div_q - div_t'(1));
    sclk       = active ? (cpol ^ (cnt >= first_half)) : cpol;
    sclk_en    = active & last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= div_t'(MIN_DIV);
      cnt   <= '0;
    end else if (load) begin
      div_q <= div_in;
      cnt   <= '0;
    end else if (!active || last) begin
      cnt   <= '0;
    end else begin
      cnt   <= cnt + div_t'(1);
    end
  end

  assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (sclk == cpol && !sclk_en));

  assert_period_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && $past(sclk_en) && !$past(load) && $stable(cpol))
      |-> (sclk == cpol && !sclk_en));

  assert_reload_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && active) |-> (sclk == cpol && !sclk_en));
endmodule

// File: rtl/spi_clk_prescaler.sv
module spi_clk_prescaler
  import spi_psc_pkg::*;
#(
  parameter bit WIDE_CODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cpol,
  input  logic              active,
  output logic              sclk,
  output logic              sclk_en
);
  div_t dec_div;

  generate
    if (WIDE_CODE) begin : g_wide
      psc_dec_wide u_dec (.code(cfg_code), .div(dec_div));
    end else begin : g_compact
      psc_dec_compact u_dec (.code(cfg_code), .div(dec_div));
    end
  endgenerate

  psc_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_we),
    .div_in  (dec_div),
    .active  (active),
    .cpol    (cpol),
    .sclk    (sclk),
    .sclk_en (sclk_en)
  );

  assert_div_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (dec_div >= div_t'(MIN_DIV) && dec_div <= div_t'(MAX_DIV)));
endmodule

// File: tb/tb_spi_clk_prescaler.sv
module tb_spi_clk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_code = 8'h00;
  logic       cpol = 1'b0;
  logic       active = 1'b0;
  logic       sclk_c, en_c, sclk_w, en_w;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spi_clk_prescaler #(.WIDE_CODE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .cpol(cpol), .active(active), .sclk(sclk_c), .sclk_en(en_c));

  spi_clk_prescaler #(.WIDE_CODE(1'b1)) dut_wide (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .cpol(cpol), .active(active), .sclk(sclk_w), .sclk_en(en_w));

  logic [3:0] q_val[$];
  string      q_req[$];
  int m_cnt_c = 0, m_div_c = 4, m_cnt_w = 0, m_div_w = 4;

  function automatic int dec_compact(input logic [7:0] f);
    int c = int'(f[4:0]);
    return (c < 18) ? 4 : 2 * (c - 16);
  endfunction

  function automatic int dec_wide(input logic [7:0] f);
    int m = (f[3:0] == 4'd0) ? 1 : int'(f[3:0]);
    int e = int'({f[7], f[6], f[4]});
    int d = m * (1 << e);
    return (d < 4) ? 4 : d;
  endfunction

  function automatic logic [1:0] expect_out(input int cnt, input int d,
                                            input logic act, input logic pol);
    logic s, e;
    s = act ? (pol ^ (cnt >= d - d / 2)) : pol;
    e = act && (cnt == d - 1);
    return {s, e};
  endfunction

  task automatic step(input logic we, input logic [7:0] f, input logic act,
                      input logic pol, input string req);
    @(negedge clk);
    cfg_we = we; cfg_code = f; active = act; cpol = pol;
    q_val.push_back({expect_out(m_cnt_c, m_div_c, act, pol),
                     expect_out(m_cnt_w, m_div_w, act, pol)});
    q_req.push_back(req);
    if (we) begin
      m_div_c = dec_compact(f); m_div_w = dec_wide(f);
      m_cnt_c = 0; m_cnt_w = 0;
    end else begin
      m_cnt_c = (!act || m_cnt_c == m_div_c - 1) ? 0 : m_cnt_c + 1;
      m_cnt_w = (!act || m_cnt_w == m_div_w - 1) ? 0 : m_cnt_w + 1;
    end
  endtask

  task automatic run_code(input logic [7:0] f, input logic pol, input string req);
    int n;
    step(1'b1, f, 1'b0, pol, req);
    n = 2 * ((dec_compact(f) > dec_wide(f)) ? dec_compact(f) : dec_wide(f)) + 3;
    for (int i = 0; i < n; i++) step(1'b0, f, 1'b1, pol, req);
    for (int i = 0; i < 3; i++) step(1'b0, f, 1'b0, pol, "R2");
  endtask

  // Monitor: pops one expected item per cycle and compares both instances
  logic [3:0] exp_v;
  string      exp_r;
  always @(negedge clk) begin
    #1;
    if (q_val.size() > 0) begin
      exp_v = q_val.pop_front();
      exp_r = q_req.pop_front();
      tests++;
      if ({sclk_c, en_c, sclk_w, en_w} !== exp_v) begin
        fails++;
        $display("FAIL %s: {sclk_c,en_c,sclk_w,en_w} actual=%b expected=%b at %0t",
                 exp_r, {sclk_c, en_c, sclk_w, en_w}, exp_v, $time);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    #1;
    tests++;
    if (sclk_c !== 1'b0 || en_c !== 1'b0 || sclk_w !== 1'b0 || en_w !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs actual=%b%b%b%b expected=0000",
               sclk_c, en_c, sclk_w, en_w);
    end
    @(negedge clk); rst_n = 1'b1;
    // R1: default divisor 4 before any write
    for (int i = 0; i < 9; i++) step(1'b0, 8'h00, 1'b1, 1'b0, "R1");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h00, 1'b0, 1'b1, "R2");
    run_code(8'h12, 1'b0, "R3");    // compact 4, wide 4
    run_code(8'h1F, 1'b0, "R3");    // compact 30, wide 30
    run_code(8'h17, 1'b1, "R8");    // compact 14, wide 14, high idle
    run_code(8'hF5, 1'b0, "R3");    // upper bits ignored: compact 10
    run_code(8'h05, 1'b0, "R5");    // compact 4 (R4), wide odd 5
    run_code(8'h11, 1'b1, "R4");    // compact 4, wide 2 raised to 4
    run_code(8'h50, 1'b0, "R6");    // wide factor 0 -> 1, exponent 3 -> 8
    run_code(8'h23, 1'b0, "R7");    // wide 3 raised to 4, bit 5 ignored
    run_code(8'h83, 1'b1, "R5");    // wide 3*16 = 48
    run_code(8'hDF, 1'b0, "R7");    // wide 1920, compact 30
    // R9: rewrite while running, mid-period
    step(1'b1, 8'h1A, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 7; i++) step(1'b0, 8'h1A, 1'b1, 1'b0, "R9");
    step(1'b1, 8'h13, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 25; i++) step(1'b0, 8'h13, 1'b1, 1'b0, "R9");
    for (int i = 0; i < 3; i++) step(1'b0, 8'h13, 1'b0, 1'b0, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule